// File: doc/BRIEF.md
# Multiprocessor-Addressed Serial Receive Filter

This block is an asynchronous serial receiver for a multi-drop line on which each frame carries an address-marker bit after its eight data bits. A receiving node that only wants frames addressed to it sets a wait control. While that control is in force, the receiver discards every frame whose marker bit is 0. It moves no data, detects no errors and raises no flags. The first frame with the marker set wakes the receiver: the wait control clears itself and that frame is delivered normally. Software then reads the address byte and decides whether to keep listening or to set the wait control again.

The line is sampled on an enable that pulses sixteen times per bit period. A start bit is confirmed at its midpoint, and each later bit is sampled at its own midpoint. A small register port gives software the control bits, the status flags and the received byte. The two interrupt outputs are levels derived from the flags and the interrupt enable. The input `rxd` must already be synchronous to `clk`.

Top module: `mp_uart_rx_filter`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the status register (address 1) reads 0x00, the data register (address 2) reads 0x00, and both interrupt outputs are low.
- R2: A frame is one low start bit, eight data bits LSB first, one marker bit when marker mode (control bit 1) is on, and one stop bit, each bit lasting 16 enable ticks. When the stop bit is sampled and the data register is empty, the byte is loaded into address 2, status bit 0 (full) is set, and status bit 3 takes the received marker bit.
- R3: `rx_irq` equals interrupt enable (control bit 0) AND full. `err_irq` equals interrupt enable AND (status bit 1 OR status bit 2).
- R4: A stop bit sampled as 0 sets status bit 1 (framing error).
- R5: A frame that completes while full is 1 sets status bit 2 (overrun) and leaves the data register unchanged.
- R6: Writing 0 to status bit 0, 1 or 2 clears that flag only if the flag was read as 1 in an earlier status read. A write without such a read leaves the flag set. Writing 1 has no effect.
- R7: A start bit that is high again at its midpoint (tick 8) is dropped, and no frame is received.
- R8: While wait (control bit 3) is 1, marker mode is on and synchronous mode (control bit 2) is off, a frame whose marker bit is 0 changes neither the data register nor any status flag, even if its stop bit is 0, and leaves wait set.
- R9: While waiting, a frame whose marker bit is 1 clears wait by hardware and is then received as in R2, R4 and R5, with status bit 3 set to 1.
- R10: Software writing 0 to wait clears it, and frames with marker 0 are then received.
- R11: Wait has no effect when marker mode is off, in which case frames have no marker bit and status bit 3 reads 0, or when synchronous mode is on.
- R12: If software clears full in the same cycle that a frame completes, the clear takes effect first: the new byte is loaded, full stays 1 and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit period |
| rxd | input | 1 | Serial receive line, idle high, synchronous to clk |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, arms status flags for clearing |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register, combinational |
| rx_irq | output | 1 | Receive interrupt level |
| err_irq | output | 1 | Receive-error interrupt level |

## Verification
A software clear of the full flag and the completion of a new frame can land on the same clock edge. The decision between a fresh load and an overrun then depends on which of the two the register logic sees first. The bench provokes this by driving the status write during the stop-bit midpoint cycle of a frame, which it computes from the tick count, after arming the flag with a read. It then expects full still set, overrun clear and the new byte in the data register. A design that let completion see the old full value would report an overrun and keep the stale byte.

// File: rtl/mpu_pkg.sv
// Package: shared register selectors, bit positions and receiver state type
// for the multiprocessor-addressed serial receive filter.
package mpu_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // control register bit positions
    localparam int CTL_IE   = 0;
    localparam int CTL_MPM  = 1;
    localparam int CTL_SYNC = 2;
    localparam int CTL_WAIT = 3;

    // status register bit positions
    localparam int ST_FULL = 0;
    localparam int ST_FERR = 1;
    localparam int ST_ORER = 2;
    localparam int ST_MPB  = 3;

    localparam int NUM_CLR_FLAGS = 3;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

endpackage

// File: rtl/mpu_rx_shift.sv
// Module: mpu_rx_shift
// Oversampling frame receiver. Detects a start bit and confirms it at its
// midpoint. Shifts data in LSB first, captures the marker bit when marker
// mode was on at frame start, and samples the stop bit.
// Assumes: rxd is synchronous to clk; OSR is a power of two >= 4.
module mpu_rx_shift #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic              mp_mode_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              mp_o,
    output logic              stop_ok_o
);
    import mpu_pkg::*;

    localparam int PH_W  = $clog2(OSR);
    localparam int MID   = OSR / 2;
    localparam int IDX_W = $clog2(DATA_W + 3);

    rx_state_e         state_q;
    logic [PH_W-1:0]   ph_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sh_q;
    logic              mp_q;
    logic              mp_frame_q;
    logic [IDX_W-1:0]  last_idx;
    logic              sample;

    // index of the stop bit for the frame in progress
    assign last_idx  = mp_frame_q ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
    // a bit midpoint is reached on this tick
    assign sample    = (state_q == RX_BUSY) && tick_i && (ph_q == PH_W'(MID));
    assign done_o    = sample && (idx_q == last_idx);
    assign data_o    = sh_q;
    assign mp_o      = mp_frame_q & mp_q;
    assign stop_ok_o = rxd_i;

    // frame sequencing: start detection, midpoint sampling, shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= RX_IDLE;
            ph_q       <= '0;
            idx_q      <= '0;
            sh_q       <= '0;
            mp_q       <= 1'b0;
            mp_frame_q <= 1'b0;
        end else if (state_q == RX_IDLE) begin
            if (tick_i && !rxd_i) begin
                state_q    <= RX_BUSY;
                ph_q       <= PH_W'(1);
                idx_q      <= '0;
                mp_q       <= 1'b0;
                mp_frame_q <= mp_mode_i;
            end
        end else if (tick_i) begin
            ph_q <= ph_q + PH_W'(1);
            if (sample) begin
                if (idx_q == '0 && rxd_i) begin
                    state_q <= RX_IDLE;
                end else if (idx_q == last_idx) begin
                    state_q <= RX_IDLE;
                end else begin
                    if (idx_q != '0 && idx_q <= IDX_W'(DATA_W)) begin
                        sh_q <= {rxd_i, sh_q[DATA_W-1:1]};
                    end else if (idx_q == IDX_W'(DATA_W + 1)) begin
                        mp_q <= rxd_i;
                    end
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_BUSY) |-> (idx_q <= last_idx)); // R2

    AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && idx_q == '0 && rxd_i) |=> (state_q == RX_IDLE)); // R7

endmodule

// File: rtl/mpu_wake_filter.sv
// Module: mpu_wake_filter
// Holds the wait-for-marker control. While active it rejects frames
// whose marker bit is 0 and clears itself on a frame with marker 1.
// Assumes: done_i is a single-cycle completion pulse.
module mpu_wake_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic frame_mp_i,
    input  logic mp_mode_i,
    input  logic sync_i,
    input  logic sw_wr_i,
    input  logic sw_val_i,
    output logic wait_o,
    output logic accept_o,
    output logic wake_o
);
    logic wait_q;
    logic active;

    // the filter only operates in asynchronous marker mode
    assign active   = wait_q && mp_mode_i && !sync_i;
    assign accept_o = done_i && !(active && !frame_mp_i);
    assign wake_o   = done_i && active && frame_mp_i;
    assign wait_o   = wait_q;

    // wait control: hardware clear on wake has priority over software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= 1'b0;
        end else if (wake_o) begin
            wait_q <= 1'b0;
        end else if (sw_wr_i) begin
            wait_q <= sw_val_i;
        end
    end

    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wait_q); // R9

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !accept_o && !sw_wr_i) |=> wait_q); // R8

endmodule

// File: rtl/mpu_rx_regs.sv
// Module: mpu_rx_regs
// Control, status and data registers with the software port. Applies
// accepted frames to the data register and flags, resolves software
// clears against same-cycle completions, and drives the interrupt levels.
// Assumes: DATA_W >= 4 so that control and status fit in one word.
module mpu_rx_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              done_i,
    input  logic              accept_i,
    input  logic [DATA_W-1:0] frame_data_i,
    input  logic              frame_mp_i,
    input  logic              stop_ok_i,
    input  logic              wait_i,
    output logic              ie_o,
    output logic              mpm_o,
    output logic              sync_o,
    output logic              wait_wr_o,
    output logic              wait_val_o,
    output logic              rx_irq_o,
    output logic              err_irq_o
);
    import mpu_pkg::*;

    logic                     ie_q, mpm_q, sync_q, mpb_q;
    logic [DATA_W-1:0]        data_q;
    logic                     flag_q  [NUM_CLR_FLAGS];
    logic                     armed_q [NUM_CLR_FLAGS];
    logic [NUM_CLR_FLAGS-1:0] clr_req, set_req, flags;
    logic                     wr_ctrl, wr_stat, rd_stat, full_eff;

    assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);
    assign wr_stat = wr_en_i && (addr_i == REG_STAT);
    assign rd_stat = rd_en_i && (addr_i == REG_STAT);

    // full as seen by a completing frame, after any same-cycle clear
    assign full_eff = flags[ST_FULL] && !clr_req[ST_FULL];

    // per-flag set conditions from an accepted frame
    always_comb begin
        set_req          = '0;
        set_req[ST_FULL] = accept_i && !full_eff;
        set_req[ST_ORER] = accept_i && full_eff;
        set_req[ST_FERR] = accept_i && !stop_ok_i;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CLR_FLAGS; gi++) begin : g_flag
            assign flags[gi]   = flag_q[gi];
            assign clr_req[gi] = wr_stat && !wdata_i[gi] && armed_q[gi];

            // flag register: a set from a frame wins over a clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q[gi] <= 1'b0;
                end else if (set_req[gi]) begin
                    flag_q[gi] <= 1'b1;
                end else if (clr_req[gi]) begin
                    flag_q[gi] <= 1'b0;
                end
            end

            // clear arming: a status read records which flags were seen set
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    armed_q[gi] <= 1'b0;
                end else if (clr_req[gi]) begin
                    armed_q[gi] <= 1'b0;
                end else if (rd_stat) begin
                    armed_q[gi] <= flag_q[gi];
                end
            end
        end
    endgenerate

    // data register and received marker bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mpb_q  <= 1'b0;
        end else begin
            if (set_req[ST_FULL]) data_q <= frame_data_i;
            if (accept_i)         mpb_q  <= frame_mp_i;
        end
    end

    // software-owned control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            mpm_q  <= 1'b0;
            sync_q <= 1'b0;
        end else if (wr_ctrl) begin
            ie_q   <= wdata_i[CTL_IE];
            mpm_q  <= wdata_i[CTL_MPM];
            sync_q <= wdata_i[CTL_SYNC];
        end
    end

    // read multiplexer
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_CTRL: begin
                rdata_o[CTL_IE]   = ie_q;
                rdata_o[CTL_MPM]  = mpm_q;
                rdata_o[CTL_SYNC] = sync_q;
                rdata_o[CTL_WAIT] = wait_i;
            end
            REG_STAT: begin
                rdata_o[ST_FULL] = flags[ST_FULL];
                rdata_o[ST_FERR] = flags[ST_FERR];
                rdata_o[ST_ORER] = flags[ST_ORER];
                rdata_o[ST_MPB]  = mpb_q;
            end
            REG_DATA: rdata_o = data_q;
            default:  rdata_o = '0;
        endcase
    end

    assign ie_o       = ie_q;
    assign mpm_o      = mpm_q;
    assign sync_o     = sync_q;
    assign wait_wr_o  = wr_ctrl;
    assign wait_val_o = wdata_i[CTL_WAIT];
    assign rx_irq_o   = ie_q && flags[ST_FULL];
    assign err_irq_o  = ie_q && (flags[ST_FERR] || flags[ST_ORER]);

    AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && flags[ST_FULL] && !wr_stat) |=> ($stable(data_q) && flags[ST_ORER])); // R5

    AST_DISCARD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !accept_i && !wr_en_i) |=> ($stable(flags) && $stable(data_q))); // R8

    AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wdata_i[ST_FULL] && flags[ST_FULL] && !armed_q[ST_FULL]) |=> flags[ST_FULL]); // R6

    AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !flags[ST_FULL]) |=> flags[ST_FULL]); // R2

endmodule

// File: rtl/mp_uart_rx_filter.sv
// Module: mp_uart_rx_filter (top)
// Asynchronous serial receiver with wait-for-marker wake-up filtering.
// Connects the frame receiver, the wake filter and the register block.
// Assumes: os_tick pulses OSR times per bit; rxd is synchronous to clk.
module mp_uart_rx_filter #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rx_irq,
    output logic              err_irq
);
    logic              done, frame_mp, stop_ok, accept, wake, wait_q;
    logic              ie, mpm, sync_mode, wait_wr, wait_val;
    logic [DATA_W-1:0] frame_data;

    mpu_rx_shift #(.DATA_W(DATA_W), .OSR(OSR)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (os_tick),
        .rxd_i     (rxd),
        .mp_mode_i (mpm),
        .done_o    (done),
        .data_o    (frame_data),
        .mp_o      (frame_mp),
        .stop_ok_o (stop_ok)
    );

    mpu_wake_filter u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done),
        .frame_mp_i (frame_mp),
        .mp_mode_i  (mpm),
        .sync_i     (sync_mode),
        .sw_wr_i    (wait_wr),
        .sw_val_i   (wait_val),
        .wait_o     (wait_q),
        .accept_o   (accept),
        .wake_o     (wake)
    );

    mpu_rx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr),
        .wr_en_i      (wr_en),
        .rd_en_i      (rd_en),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .done_i       (done),
        .accept_i     (accept),
        .frame_data_i (frame_data),
        .frame_mp_i   (frame_mp),
        .stop_ok_i    (stop_ok),
        .wait_i       (wait_q),
        .ie_o         (ie),
        .mpm_o        (mpm),
        .sync_o       (sync_mode),
        .wait_wr_o    (wait_wr),
        .wait_val_o   (wait_val),
        .rx_irq_o     (rx_irq),
        .err_irq_o    (err_irq)
    );

    AST_WAKE_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (done && accept)); // R9

endmodule

// File: tb/test_mp_uart_rx_filter.sv
module test_mp_uart_rx_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       rx_irq, err_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mp_uart_rx_filter i_mp_uart_rx_filter (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .rx_irq(rx_irq), .err_irq(err_irq)
    );

    // {data, marker bit, stop bit}
    localparam logic [9:0] VEC [6] = '{
        {8'hA5, 1'b0, 1'b1}, {8'h3C, 1'b1, 1'b1}, {8'hFF, 1'b0, 1'b0},
        {8'h00, 1'b1, 1'b1}, {8'h81, 1'b1, 1'b0}, {8'h5A, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // send one frame; optionally clear full at the stop-bit midpoint edge
    task automatic send(input logic [7:0] d, input logic mp, input logic with_mp,
                        input logic stop, input logic collide);
        logic [10:0] bits;
        int nb;
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[1+i] = d[i];
        if (with_mp) begin bits[9] = mp; bits[10] = stop; nb = 11; end
        else begin bits[9] = stop; nb = 10; end
        for (int k = 0; k < nb; k++) begin
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                rxd = bits[k];
                if (collide && k == nb - 1 && j == 8) begin
                    addr = 2'd1; wdata = 8'h00; wr_en = 1'b1;
                end else if (collide && k == nb - 1 && j == 9) begin
                    wr_en = 1'b0;
                end
            end
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic clear_all;
        logic [7:0] v;
        rd(2'd1, v);
        wr(2'd1, 8'h00);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1", "ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1", "status", v, 8'h00);
        rd(2'd2, v); chk("R1", "data", v, 8'h00);
        chk("R1", "irqs", {6'd0, rx_irq, err_irq}, 8'h00);

        // table walk: normal reception in marker mode with interrupts on
        wr(2'd0, 8'h03);
        for (int n = 0; n < 6; n++) begin
            logic [7:0] d; logic m, s;
            {d, m, s} = VEC[n];
            send(d, m, 1'b1, s, 1'b0);
            rd(2'd1, v);
            chk("R2/R4", "status", v, {4'd0, m, 1'b0, ~s, 1'b1});
            rd(2'd2, v); chk("R2", "data", v, d);
            chk("R3", "irqs", {6'd0, rx_irq, err_irq}, {6'd0, 1'b1, ~s});
            wr(2'd1, 8'h00);
            rd(2'd1, v); chk("R6", "cleared status", v, {4'd0, m, 3'd0});
        end

        // R6 clear without prior read is ignored
        send(8'h11, 1'b0, 1'b1, 1'b1, 1'b0);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R6", "unarmed clear", v, 8'h01);

        // R5 overrun keeps old data
        send(8'h22, 1'b0, 1'b1, 1'b1, 1'b0);
        rd(2'd2, v); chk("R5", "data kept", v, 8'h11);
        rd(2'd1, v); chk("R5", "overrun flag", v, 8'h05);
        chk("R3", "err_irq on overrun", {7'd0, err_irq}, 8'h01);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R6", "clear after overrun", v, 8'h00);

        // R7 short start glitch
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (30) @(negedge clk);
        rd(2'd1, v); chk("R7", "glitch status", v, 8'h00);
        rd(2'd2, v); chk("R7", "glitch data", v, 8'h11);

        // R8 waiting receiver discards marker-0 frames
        wr(2'd0, 8'h0B);
        rd(2'd0, v); chk("R8", "wait set", v, 8'h0B);
        send(8'h77, 1'b0, 1'b1, 1'b1, 1'b0);
        send(8'h66, 1'b0, 1'b1, 1'b0, 1'b0);
        rd(2'd1, v); chk("R8", "no flags", v, 8'h00);
        rd(2'd2, v); chk("R8", "data untouched", v, 8'h11);
        rd(2'd0, v); chk("R8", "still waiting", v, 8'h0B);

        // R9 marker-1 frame wakes the receiver
        send(8'h42, 1'b1, 1'b1, 1'b1, 1'b0);
        rd(2'd0, v); chk("R9", "wait cleared", v, 8'h03);
        rd(2'd1, v); chk("R9", "status", v, 8'h09);
        rd(2'd2, v); chk("R9", "data", v, 8'h42);
        chk("R9", "rx_irq", {7'd0, rx_irq}, 8'h01);
        wr(2'd1, 8'h00);

        // R10 software clears wait
        wr(2'd0, 8'h0B);
        wr(2'd0, 8'h03);
        send(8'h99, 1'b0, 1'b1, 1'b1, 1'b0);
        rd(2'd1, v); chk("R10", "status", v, 8'h01);
        rd(2'd2, v); chk("R10", "data", v, 8'h99);
        wr(2'd1, 8'h00);

        // R11 wait ignored with marker mode off (10-bit frame)
        wr(2'd0, 8'h09);
        send(8'h6E, 1'b0, 1'b0, 1'b1, 1'b0);
        rd(2'd1, v); chk("R11", "no-marker status", v, 8'h01);
        rd(2'd2, v); chk("R11", "no-marker data", v, 8'h6E);
        rd(2'd0, v); chk("R11", "wait kept", v, 8'h09);
        wr(2'd1, 8'h00);

        // R11 wait ignored in synchronous mode
        wr(2'd0, 8'h0F);
        send(8'h35, 1'b0, 1'b1, 1'b1, 1'b0);
        rd(2'd1, v); chk("R11", "sync status", v, 8'h01);
        rd(2'd2, v); chk("R11", "sync data", v, 8'h35);
        wr(2'd1, 8'h00);

        // R12 clear of full coincides with frame completion
        wr(2'd0, 8'h03);
        send(8'hC3, 1'b0, 1'b1, 1'b1, 1'b0);
        rd(2'd1, v); chk("R12", "pre status", v, 8'h01);
        send(8'h3C, 1'b0, 1'b1, 1'b1, 1'b1);
        rd(2'd1, v); chk("R12", "no overrun", v, 8'h01);
        rd(2'd2, v); chk("R12", "new data", v, 8'h3C);
        clear_all();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule